// File: doc/BRIEF.md
# Exception Pending/Active Tracker and Arbiter

This block keeps the bookkeeping a small processor core needs to decide which exception handler to run next. For every exception source it holds two independent state bits: pending and active. Together they give the four legal states: inactive, pending, active, and active with a new request pending. Requests come from a non-maskable interrupt line, a fault strobe, three system-service requests (supervisor call, deferred service, system timer), a vector of peripheral interrupt lines, and per-interrupt software set-pending strobes.

Every configurable exception has a small priority register. The non-maskable interrupt and the fault exception sit on fixed levels above all configurable ones. The block always presents the best pending exception, with its number and vector-table address. It raises a preemption request when that exception outranks the priority of the handlers now running. It also reports that running priority. The core answers with an entry acknowledge when it enters a handler and with a return strobe when it leaves one. Handlers may nest to any depth. After reset the block first presents the reset entry, and nothing is active or pending.

Top module: `exc_ctrl`

## Requirements
- R1: After reset is released, the outputs are exc_valid_o=1, exc_num_o=1, vec_addr_o=0x4, preempt_o=1 and run_level_o=7 (idle) until the first accepted acknowledge. After that acknowledge nothing is pending or active: exc_valid_o=0, preempt_o=0 and run_level_o=7.
- R2: A high level on any request input in a cycle makes that exception pending from the next cycle on. The request inputs are a peripheral line, its software set-pending strobe, nmi_i, fault_i, svc_i, defer_i and tick_i.
- R3: Exception numbers are fixed: NMI 2, fault 3, supervisor call 11, deferred service 14, system timer 15, and peripheral interrupt n is 16+n. vec_addr_o always equals exc_num_o times 4. exc_num_o is 0 when nothing is pending.
- R4: The level encoding, from highest to lowest, is: reset entry 0, NMI 1, fault 2, configurable priority p as p+3, and idle 7. With nothing pending or active, run_level_o is 7.
- R5: Writing prio_wdata_i with prio_we_i=1 sets a configurable priority. prio_sel_i selects the target: 0 supervisor call, 1 deferred service, 2 system timer, 3+n interrupt n. A lower value means a higher priority. All priorities reset to 0.
- R6: Among pending exceptions of equal level, the one with the lower exception number is presented.
- R7: preempt_o is 1 only when the presented pending level is strictly lower in number than run_level_o. The reset entry is the one exception to this rule.
- R8: An acknowledge taken while preempt_o=1 makes the presented exception active and clears its pending bit. run_level_o then becomes that exception's level.
- R9: A request for an exception that is already active leaves it active and pending. After its return it is presented as pending again.
- R10: A return removes only the highest-priority active exception. run_level_o then falls back to the next active level, or to 7 if none is left.
- R11: Nothing can preempt an active NMI. A pending fault does not raise preempt_o while an NMI handler runs. NMI preempts any configurable handler.
- R12: An acknowledge while preempt_o=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable interrupt request |
| fault_i | input | 1 | Fault strobe |
| svc_i | input | 1 | Supervisor-call request |
| defer_i | input | 1 | Deferred-service request |
| tick_i | input | 1 | System-timer request |
| irq_i | input | N_IRQ | Peripheral interrupt lines |
| swpend_i | input | N_IRQ | Software set-pending strobes per interrupt |
| prio_we_i | input | 1 | Priority register write enable |
| prio_sel_i | input | SEL_W | Priority register select |
| prio_wdata_i | input | PRIO_W | Priority value to write |
| ack_i | input | 1 | Handler-entry acknowledge |
| ret_i | input | 1 | Handler-return strobe |
| exc_valid_o | output | 1 | An exception is presented |
| exc_num_o | output | EXC_W | Presented exception number |
| vec_addr_o | output | EXC_W+2 | Vector-table address of the presented exception |
| preempt_o | output | 1 | Preemption request |
| run_level_o | output | LVL_W | Current running priority level |

## Verification
On every cycle the assertions check the following. A request always yields a presented exception one cycle later. No preemption is requested with nothing presented. The reset entry is only presented while idle. Only legal exception numbers appear. An accepted acknowledge moves the running level to the acknowledged level. A return never raises the running priority. An active NMI is never preempted. The bench scenarios show what the assertions cannot: that equal levels resolve to the lower number, that a request during a handler comes back after its return, that programmed priorities reorder the winners, and that nested returns unwind in the right order.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // Level encoding: smaller is more urgent
  localparam int LV_BOOT     = 0;
  localparam int LV_NMI      = 1;
  localparam int LV_FAULT    = 2;
  localparam int LV_CFG_BASE = 3;
  // Slot layout: 0 NMI, 1 fault, 2 svc, 3 deferred, 4 timer, 5.. irq
  localparam int N_SYS_SLOTS = 5;
  localparam int N_CFG_SYS   = 3;
  localparam int RESET_NUM   = 1;
  localparam int IRQ_BASE    = 16;

  function automatic int slot_num(input int s);
    case (s)
      0:       return 2;
      1:       return 3;
      2:       return 11;
      3:       return 14;
      4:       return 15;
      default: return IRQ_BASE + s - N_SYS_SLOTS;
    endcase
  endfunction
endpackage

// File: rtl/exc_prio_regs.sv
module exc_prio_regs #(
  parameter int N_CFG  = 11,
  parameter int PRIO_W = 2,
  localparam int SEL_W = $clog2(N_CFG)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [SEL_W-1:0]              sel,
  input  logic [PRIO_W-1:0]             wdata,
  output logic [N_CFG-1:0][PRIO_W-1:0]  prio_o
);
  logic [N_CFG-1:0][PRIO_W-1:0] prio_q, prio_d;

  always_comb begin
    prio_d = prio_q;
    for (int i = 0; i < N_CFG; i++) begin
      if (we && (int'(sel) == i)) prio_d[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_q <= '0;
    else        prio_q <= prio_d;
  end

  assign prio_o = prio_q;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N     = 13,
  parameter int LVL_W = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]             req,
  input  logic [N-1:0][LVL_W-1:0]  rank,
  output logic                     found,
  output logic [IDX_W-1:0]         best_idx,
  output logic [LVL_W-1:0]         best_rank
);
  // Strict compare keeps the lowest slot, hence lowest number, on ties
  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_rank = '1;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || (rank[i] < best_rank))) begin
        found     = 1'b1;
        best_idx  = IDX_W'(i);
        best_rank = rank[i];
      end
    end
  end
endmodule

// File: rtl/exc_state.sv
module exc_state #(
  parameter int N_SLOT = 13,
  localparam int IDX_W = $clog2(N_SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SLOT-1:0] req_vec,
  input  logic              ack_en,
  input  logic [IDX_W-1:0]  ack_idx,
  input  logic              ret_en,
  input  logic [IDX_W-1:0]  ret_idx,
  output logic [N_SLOT-1:0] pend_o,
  output logic [N_SLOT-1:0] act_o
);
  logic [N_SLOT-1:0] pend_q, pend_d, act_q, act_d;
  logic [N_SLOT-1:0] ack_mask, ret_mask;

  always_comb begin
    ack_mask = ack_en ? (N_SLOT'(1) << ack_idx) : '0;
    ret_mask = ret_en ? (N_SLOT'(1) << ret_idx) : '0;
    // A request in the acknowledge cycle survives: active and pending
    pend_d   = (pend_q & ~ack_mask) | req_vec;
    act_d    = (act_q & ~ret_mask) | ack_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 2,
  localparam int N_CFG = N_CFG_SYS + N_IRQ,
  localparam int SEL_W = $clog2(N_CFG),
  localparam int EXC_W = $clog2(IRQ_BASE + N_IRQ),
  localparam int LVL_W = $clog2((2 ** PRIO_W) + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic              fault_i,
  input  logic              svc_i,
  input  logic              defer_i,
  input  logic              tick_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic [N_IRQ-1:0]  swpend_i,
  input  logic              prio_we_i,
  input  logic [SEL_W-1:0]  prio_sel_i,
  input  logic [PRIO_W-1:0] prio_wdata_i,
  input  logic              ack_i,
  input  logic              ret_i,
  output logic              exc_valid_o,
  output logic [EXC_W-1:0]  exc_num_o,
  output logic [EXC_W+1:0]  vec_addr_o,
  output logic              preempt_o,
  output logic [LVL_W-1:0]  run_level_o
);
  localparam int N_SLOT = N_SYS_SLOTS + N_IRQ;
  localparam int IDX_W  = $clog2(N_SLOT);

  logic [N_CFG-1:0][PRIO_W-1:0] prio;
  logic [N_SLOT-1:0][LVL_W-1:0] rank;
  logic [N_SLOT-1:0]            req_vec, pend, act;
  logic                         pend_found, act_found;
  logic [IDX_W-1:0]             pend_idx, act_idx;
  logic [LVL_W-1:0]             pend_rank, act_rank, win_level;
  logic                         boot_q, boot_d;
  logic                         ack_take, ret_take;

  assign req_vec = {irq_i | swpend_i, tick_i, defer_i, svc_i, fault_i, nmi_i};

  exc_prio_regs #(.N_CFG(N_CFG), .PRIO_W(PRIO_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .we(prio_we_i), .sel(prio_sel_i),
    .wdata(prio_wdata_i), .prio_o(prio)
  );

  for (genvar s = 0; s < N_SLOT; s++) begin : g_rank
    if (s == 0) begin : g_nmi
      assign rank[s] = LVL_W'(LV_NMI);
    end else if (s == 1) begin : g_fault
      assign rank[s] = LVL_W'(LV_FAULT);
    end else begin : g_cfg
      assign rank[s] = LVL_W'(prio[s-2]) + LVL_W'(LV_CFG_BASE);
    end
  end

  exc_arbiter #(.N(N_SLOT), .LVL_W(LVL_W)) u_pend_arb (
    .req(pend), .rank(rank), .found(pend_found),
    .best_idx(pend_idx), .best_rank(pend_rank)
  );

  exc_arbiter #(.N(N_SLOT), .LVL_W(LVL_W)) u_act_arb (
    .req(act), .rank(rank), .found(act_found),
    .best_idx(act_idx), .best_rank(act_rank)
  );

  // Reset entry is presented once after reset, ahead of everything
  always_comb begin
    boot_d = boot_q & ~ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= boot_d;
  end

  always_comb begin
    preempt_o   = boot_q | (pend_found && (pend_rank < act_rank));
    ack_take    = ack_i & preempt_o & ~boot_q;
    ret_take    = ret_i & act_found;
    run_level_o = act_rank;
    exc_valid_o = boot_q | pend_found;
    win_level   = boot_q ? LVL_W'(LV_BOOT) : pend_rank;
    if (boot_q)          exc_num_o = EXC_W'(RESET_NUM);
    else if (pend_found) exc_num_o = EXC_W'(slot_num(int'(pend_idx)));
    else                 exc_num_o = '0;
    vec_addr_o = {exc_num_o, 2'b00};
  end

  exc_state #(.N_SLOT(N_SLOT)) u_state (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec),
    .ack_en(ack_take), .ack_idx(pend_idx),
    .ret_en(ret_take), .ret_idx(act_idx),
    .pend_o(pend), .act_o(act)
  );
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int N_SLOT = 13,
  parameter int EXC_W  = 5,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SLOT-1:0] req_vec,
  input logic              ack_i,
  input logic              ret_i,
  input logic              exc_valid_o,
  input logic [EXC_W-1:0]  exc_num_o,
  input logic              preempt_o,
  input logic [LVL_W-1:0]  run_level_o,
  input logic [LVL_W-1:0]  win_level
);
  localparam logic [LVL_W-1:0] IDLE = '1;

  // R2
  req_presented_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_vec) |=> exc_valid_o);

  // R7
  no_idle_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid_o |-> !preempt_o);

  // R1
  reset_entry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_num_o == EXC_W'(1)) |-> (run_level_o == IDLE && preempt_o));

  // R3
  legal_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_o |-> (exc_num_o inside {EXC_W'(1), EXC_W'(2), EXC_W'(3), EXC_W'(11),
                                       EXC_W'(14), EXC_W'(15)} || exc_num_o >= EXC_W'(16)));

  // R8
  ack_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && preempt_o && exc_num_o != EXC_W'(1) && !ret_i) |=> (run_level_o == $past(win_level)));

  // R10
  ret_unwind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !ack_i) |=> (run_level_o >= $past(run_level_o)));

  // R11
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_level_o == LVL_W'(1) && exc_num_o != EXC_W'(1)) |-> !preempt_o);
endmodule

bind exc_ctrl exc_ctrl_chk #(.N_SLOT(N_SLOT), .EXC_W(EXC_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .ack_i(ack_i), .ret_i(ret_i),
  .exc_valid_o(exc_valid_o), .exc_num_o(exc_num_o), .preempt_o(preempt_o),
  .run_level_o(run_level_o), .win_level(win_level)
);

// File: tb/exc_ctrl_bench.sv
module exc_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NI    = 8;

  typedef struct packed {
    logic [7:0] rq;
    logic nmi, flt, svc, dfr, tck;
    logic [7:0] irq, sw;
    logic ack, ret;
    logic ev;
    logic [4:0] en;
    logic ep;
    logic [2:0] er;
  } step_t;

  localparam int NSTEP = 27;
  localparam step_t TBL [NSTEP] = '{
    '{8'd2,  0,0,0,0,0, 8'h04, 8'h00, 0,0, 1,5'd18,1,3'd7}, // R2 irq2
    '{8'd8,  0,0,0,0,0, 8'h00, 8'h00, 1,0, 0,5'd0, 0,3'd3}, // R8
    '{8'd9,  0,0,0,0,0, 8'h04, 8'h00, 0,0, 1,5'd18,0,3'd3}, // R9 again while active
    '{8'd6,  0,0,0,0,0, 8'h01, 8'h00, 0,0, 1,5'd16,0,3'd3}, // R6 tie
    '{8'd11, 1,0,0,0,0, 8'h00, 8'h00, 0,0, 1,5'd2, 1,3'd3}, // R11 nmi preempts
    '{8'd4,  0,0,0,0,0, 8'h00, 8'h00, 1,0, 1,5'd16,0,3'd1}, // R4 nmi level
    '{8'd11, 0,1,0,0,0, 8'h00, 8'h00, 0,0, 1,5'd3, 0,3'd1}, // R11 fault held off
    '{8'd10, 0,0,0,0,0, 8'h00, 8'h00, 0,1, 1,5'd3, 1,3'd3}, // R10
    '{8'd4,  0,0,0,0,0, 8'h00, 8'h00, 1,0, 1,5'd16,0,3'd2}, // R4 fault level
    '{8'd10, 0,0,0,0,0, 8'h00, 8'h00, 0,1, 1,5'd16,0,3'd3}, // R10
    '{8'd9,  0,0,0,0,0, 8'h00, 8'h00, 0,1, 1,5'd16,1,3'd7}, // R9
    '{8'd8,  0,0,0,0,0, 8'h00, 8'h00, 1,0, 1,5'd18,0,3'd3}, // R8
    '{8'd10, 0,0,0,0,0, 8'h00, 8'h00, 0,1, 1,5'd18,1,3'd7}, // R10
    '{8'd8,  0,0,0,0,0, 8'h00, 8'h00, 1,0, 0,5'd0, 0,3'd3}, // R8
    '{8'd10, 0,0,0,0,0, 8'h00, 8'h00, 0,1, 0,5'd0, 0,3'd7}, // R10
    '{8'd12, 0,0,0,0,0, 8'h00, 8'h00, 1,0, 0,5'd0, 0,3'd7}, // R12
    '{8'd2,  0,0,0,0,0, 8'h00, 8'h20, 0,0, 1,5'd21,1,3'd7}, // R2 swpend5
    '{8'd6,  0,0,1,0,0, 8'h00, 8'h00, 0,0, 1,5'd11,1,3'd7}, // R6
    '{8'd6,  0,0,0,1,1, 8'h00, 8'h00, 0,0, 1,5'd11,1,3'd7}, // R6
    '{8'd8,  0,0,0,0,0, 8'h00, 8'h00, 1,0, 1,5'd14,0,3'd3}, // R8
    '{8'd3,  0,0,0,0,0, 8'h00, 8'h00, 0,1, 1,5'd14,1,3'd7}, // R3
    '{8'd3,  0,0,0,0,0, 8'h00, 8'h00, 1,0, 1,5'd15,0,3'd3}, // R3
    '{8'd3,  0,0,0,0,0, 8'h00, 8'h00, 0,1, 1,5'd15,1,3'd7}, // R3
    '{8'd3,  0,0,0,0,0, 8'h00, 8'h00, 1,0, 1,5'd21,0,3'd3}, // R3
    '{8'd3,  0,0,0,0,0, 8'h00, 8'h00, 0,1, 1,5'd21,1,3'd7}, // R3
    '{8'd8,  0,0,0,0,0, 8'h00, 8'h00, 1,0, 0,5'd0, 0,3'd3}, // R8
    '{8'd10, 0,0,0,0,0, 8'h00, 8'h00, 0,1, 0,5'd0, 0,3'd7}  // R10
  };

  logic clk, rst_n;
  logic nmi_i, fault_i, svc_i, defer_i, tick_i;
  logic [NI-1:0] irq_i, swpend_i;
  logic prio_we_i;
  logic [3:0] prio_sel_i;
  logic [1:0] prio_wdata_i;
  logic ack_i, ret_i;
  logic exc_valid_o, preempt_o;
  logic [4:0] exc_num_o;
  logic [6:0] vec_addr_o;
  logic [2:0] run_level_o;

  int n_chk, n_err;
  bit done;

  exc_ctrl #(.N_IRQ(NI), .PRIO_W(2)) u_exc_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .fault_i(fault_i), .svc_i(svc_i),
    .defer_i(defer_i), .tick_i(tick_i), .irq_i(irq_i), .swpend_i(swpend_i),
    .prio_we_i(prio_we_i), .prio_sel_i(prio_sel_i), .prio_wdata_i(prio_wdata_i),
    .ack_i(ack_i), .ret_i(ret_i), .exc_valid_o(exc_valid_o), .exc_num_o(exc_num_o),
    .vec_addr_o(vec_addr_o), .preempt_o(preempt_o), .run_level_o(run_level_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic idle_inputs();
    nmi_i = 0; fault_i = 0; svc_i = 0; defer_i = 0; tick_i = 0;
    irq_i = '0; swpend_i = '0; ack_i = 0; ret_i = 0;
    prio_we_i = 0; prio_sel_i = '0; prio_wdata_i = '0;
  endtask

  task automatic expect_out(input string rq, input logic ev, input logic [4:0] en,
                            input logic ep, input logic [2:0] er);
    n_chk++;
    if ({exc_valid_o, exc_num_o, preempt_o, run_level_o} !== {ev, en, ep, er}) begin
      n_err++;
      $display("FAIL %s: got valid=%0d num=%0d preempt=%0d run=%0d, expected valid=%0d num=%0d preempt=%0d run=%0d",
               rq, exc_valid_o, exc_num_o, preempt_o, run_level_o, ev, en, ep, er);
    end
    n_chk++;
    if (vec_addr_o !== {en, 2'b00}) begin
      n_err++;
      $display("FAIL R3 vector: got %0h expected %0h", vec_addr_o, {en, 2'b00});
    end
  endtask

  // Called at a negedge: drive, cross one posedge, sample at the next negedge
  task automatic apply(input step_t s);
    nmi_i = s.nmi; fault_i = s.flt; svc_i = s.svc; defer_i = s.dfr; tick_i = s.tck;
    irq_i = s.irq; swpend_i = s.sw; ack_i = s.ack; ret_i = s.ret;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    expect_out($sformatf("R%0d", s.rq), s.ev, s.en, s.ep, s.er);
  endtask

  function automatic step_t mk(input logic [7:0] rq, input logic svc, input logic tck,
                               input logic [7:0] irq, input logic ack, input logic ret,
                               input logic ev, input logic [4:0] en, input logic ep,
                               input logic [2:0] er);
    return '{rq, 1'b0, 1'b0, svc, 1'b0, tck, irq, 8'h00, ack, ret, ev, en, ep, er};
  endfunction

  task automatic write_prio(input logic [3:0] sel, input logic [1:0] val);
    prio_we_i = 1; prio_sel_i = sel; prio_wdata_i = val;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_out("R1 reset entry", 1, 5'd1, 1, 3'd7);
    apply(mk(8'd1, 0, 0, 8'h00, 1, 0, 0, 5'd0, 0, 3'd7)); // R1 leave reset entry

    for (int i = 0; i < NSTEP; i++) apply(TBL[i]);

    // R5: programmed priorities reorder winners
    write_prio(4'd0, 2'd2);   // svc -> level 5
    write_prio(4'd4, 2'd0);   // irq1 -> level 3
    write_prio(4'd2, 2'd3);   // timer -> level 6
    apply(mk(8'd5, 1, 0, 8'h02, 0, 0, 1, 5'd17, 1, 3'd7)); // R5
    apply(mk(8'd5, 0, 0, 8'h00, 1, 0, 1, 5'd11, 0, 3'd3)); // R5
    apply(mk(8'd10, 0, 0, 8'h00, 0, 1, 1, 5'd11, 1, 3'd7)); // R10
    apply(mk(8'd5, 0, 0, 8'h00, 1, 0, 0, 5'd0, 0, 3'd5));  // R5 svc level
    apply(mk(8'd7, 0, 1, 8'h00, 0, 0, 1, 5'd15, 0, 3'd5)); // R7 lower level waits
    apply(mk(8'd7, 0, 0, 8'h00, 0, 1, 1, 5'd15, 1, 3'd7)); // R7
    apply(mk(8'd5, 0, 0, 8'h00, 1, 0, 0, 5'd0, 0, 3'd6));  // R5 timer level
    apply(mk(8'd10, 0, 0, 8'h00, 0, 1, 0, 5'd0, 0, 3'd7)); // R10

    // R1: reset in mid-service clears everything
    apply(mk(8'd2, 0, 0, 8'h08, 0, 0, 1, 5'd19, 1, 3'd7)); // R2
    apply(mk(8'd8, 0, 0, 8'h00, 1, 0, 0, 5'd0, 0, 3'd3));  // R8
    irq_i = 8'h01;
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_out("R1 reset mid-run", 1, 5'd1, 1, 3'd7);
    apply(mk(8'd1, 0, 0, 8'h00, 1, 0, 0, 5'd0, 0, 3'd7)); // R1 nothing left
    finish_run();
  end
endmodule